// File: doc/BRIEF.md
# Single-Wire Host Interrupt Signaller

This block attaches to a bidirectional, open-drain, single-wire serial data line on which it is normally a slave. It watches the line for a break, a low level held long enough to mark the start of a host transaction, and pulses a reset to the receive framer when it sees one. The line only counts as quiet, and ready for traffic, after it has been high for a recovery time.

Once software enables it with a set strobe, the block can briefly become the bus master to signal an alert to the host. While the alert flag is high, each one-second tick requests one fixed one-byte message, the value 0x80, with no data byte after it. Requests stop when a clear strobe arrives or when the number of messages since the flag last rose reaches a programmable limit. There is no arbitration, so a requested message waits until the line has been quiet for the recovery time and is only then driven.

Top module: `swire_alert_signaller`

## Requirements
- R1: After reset the line is released (`line_pull` low), `busy` and `framer_rst` are low, and the feature is disabled.
- R2: While disabled, ticks with the alert flag high produce no message.
- R3: A message is exactly eight bit cells of CELL_CYC clocks carrying 0x80 LSB first. Each cell starts with a low pulse: LOW1_CYC clocks for a 1 and LOW0_CYC clocks for a 0. No further cell follows the eighth.
- R4: While enabled with the alert flag high, each tick produces one message.
- R5: No more than `tries_max` messages are sent between resets of the try count. A limit of 0 sends none.
- R6: A clear strobe disables the feature and drops any waiting request. A tick in the same cycle as a clear sends nothing, and a clear wins over a set in the same cycle.
- R7: The try count returns to zero when the alert flag falls or when a set strobe arrives, so messages resume after either.
- R8: A message starts only after the line has been high for RCV_CYC clocks. A tick while the host holds the line low is deferred, not lost.
- R9: `framer_rst` pulses once when the line has been low for BRK_CYC consecutive clocks. A low of BRK_CYC-1 clocks gives no pulse.
- R10: The line is pulled low only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled level of the data line |
| line_pull | output | 1 | 1 = pull the line low, 0 = release it |
| busy | output | 1 | A message is being sent |
| framer_rst | output | 1 | One-clock pulse when a break is detected |
| alert_flag | input | 1 | Alert condition from the alert-configuration logic |
| en_set | input | 1 | Enable strobe, also clears the try count |
| en_clr | input | 1 | Disable strobe |
| tries_max | input | TRY_W | Maximum messages per alert episode |
| tick_1s | input | 1 | One-clock pulse every second |

## Verification
Two pairs of events can fall in the same cycle. The first is a tick landing together with a clear strobe, which the bench provokes by driving both in one cycle and judges by seeing no pulse on the line afterwards. The second is a tick arriving while the host holds the line low. The bench issues the tick in the middle of a host low shorter than a break and checks two things: no pull is observed during the hold, and exactly one well-formed message appears after the line has recovered.

// File: rtl/swa_pkg.sv
// Shared constants for the single-wire alert signaller.
// Assumes: the alert message is a fixed byte with no payload.
package swa_pkg;
    localparam logic [7:0] ALERT_BYTE = 8'h80;
    localparam int         MSG_BITS   = 8;
endpackage

// File: rtl/swa_break_det.sv
// Line monitor: flags a break after BRK_CYC low clocks and reports the line
// as idle after RCV_CYC consecutive high clocks.
// Assumes: line_in is already synchronised to clk.
module swa_break_det #(
    parameter int BRK_CYC = 30,
    parameter int RCV_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic framer_rst,
    output logic line_idle
);
    localparam int LW = $clog2(BRK_CYC + 1);
    localparam int HW = $clog2(RCV_CYC + 1);

    logic [LW-1:0] lo_cnt;
    logic [HW-1:0] hi_cnt;
    logic          brk_q;

    // Count consecutive low clocks and emit one break pulse on reaching BRK_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            brk_q  <= 1'b0;
        end else begin
            brk_q <= !line_in && (lo_cnt == LW'(BRK_CYC - 1));
            if (line_in)
                lo_cnt <= '0;
            else if (lo_cnt != LW'(BRK_CYC))
                lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Count consecutive high clocks, saturating at the recovery time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!line_in)
            hi_cnt <= '0;
        else if (hi_cnt != HW'(RCV_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    assign framer_rst = brk_q;
    assign line_idle  = (hi_cnt == HW'(RCV_CYC));

    // R9: a break pulse is always preceded by a low line sample
    a_r9_break_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> $past(!line_in));
    // R9: break pulses are single-cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |=> !brk_q);
endmodule

// File: rtl/swa_tx_ser.sv
// Serialiser for the fixed alert byte: LSB first, each cell begins with a
// low pulse whose length encodes the bit (short = 1, long = 0).
// Assumes: LOW1_CYC < LOW0_CYC < CELL_CYC; start only while not busy.
module swa_tx_ser #(
    parameter int CELL_CYC = 20,
    parameter int LOW1_CYC = 4,
    parameter int LOW0_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic line_pull,
    output logic busy
);
    import swa_pkg::*;

    localparam int CW = $clog2(CELL_CYC);
    localparam int BW = $clog2(MSG_BITS);

    logic          busy_q;
    logic [CW-1:0] cyc_cnt;
    logic [BW-1:0] bit_idx;
    logic [CW-1:0] low_len;
    logic          cell_end;

    // Low-pulse length of the bit being sent.
    always_comb begin
        low_len = ALERT_BYTE[bit_idx] ? CW'(LOW1_CYC) : CW'(LOW0_CYC);
    end

    assign cell_end = (cyc_cnt == CW'(CELL_CYC - 1));

    // Step through the cells of the message and stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cyc_cnt <= '0;
            bit_idx <= '0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            cyc_cnt <= '0;
            bit_idx <= '0;
        end else if (busy_q) begin
            if (cell_end) begin
                cyc_cnt <= '0;
                if (bit_idx == BW'(MSG_BITS - 1))
                    busy_q <= 1'b0;
                else
                    bit_idx <= bit_idx + 1'b1;
            end else begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
        end
    end

    assign line_pull = busy_q && (cyc_cnt < low_len);
    assign busy      = busy_q;

    // R3: a new message is never launched over a running one
    a_r3_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    // R3: every message opens with a low pulse
    a_r3_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> line_pull);
endmodule

// File: rtl/swa_retry_ctrl.sv
// Enable state, try counting and request hand-off for alert messages.
// Assumes: tick_1s and the command strobes are single-cycle pulses.
module swa_retry_ctrl #(
    parameter int TRY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alert_flag,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [TRY_W-1:0] tries_max,
    input  logic             tick_1s,
    input  logic             line_idle,
    input  logic             tx_busy,
    output logic             start
);
    logic             en_q;
    logic             pending_q;
    logic [TRY_W-1:0] tries_used;
    logic             accept;

    assign accept = tick_1s && en_q && !en_clr && !en_set && alert_flag
                    && !pending_q && (tries_used < tries_max);
    assign start  = pending_q && line_idle && !tx_busy;

    // Feature enable: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_clr)
            en_q <= 1'b0;
        else if (en_set)
            en_q <= 1'b1;
    end

    // Tries spent in this alert episode; reset on alert drop or re-enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tries_used <= '0;
        else if (!alert_flag || en_set)
            tries_used <= '0;
        else if (accept)
            tries_used <= tries_used + 1'b1;
    end

    // One outstanding request, waiting for a quiet line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (en_clr || !alert_flag)
            pending_q <= 1'b0;
        else if (start)
            pending_q <= 1'b0;
        else if (accept)
            pending_q <= 1'b1;
    end

    // R2: no request can exist while the feature is disabled
    a_r2_no_request_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pending_q);
    // R5: a request is raised only while tries remain
    a_r5_under_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> ($past(tries_used) < $past(tries_max)));
    // R6: a clear leaves the feature disabled with nothing waiting
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (!en_q && !pending_q));
endmodule

// File: rtl/swire_alert_signaller.sv
// Top level: single-wire line monitor plus occasional alert master.
// Assumes: line_in reflects the wired-AND of all drivers, including line_pull.
module swire_alert_signaller #(
    parameter int CELL_CYC = 20,
    parameter int LOW1_CYC = 4,
    parameter int LOW0_CYC = 12,
    parameter int BRK_CYC  = 30,
    parameter int RCV_CYC  = 8,
    parameter int TRY_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             line_pull,
    output logic             busy,
    output logic             framer_rst,
    input  logic             alert_flag,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [TRY_W-1:0] tries_max,
    input  logic             tick_1s
);
    logic line_idle;
    logic start;
    logic tx_busy;

    swa_break_det #(.BRK_CYC(BRK_CYC), .RCV_CYC(RCV_CYC)) u_brk (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .framer_rst(framer_rst), .line_idle(line_idle)
    );

    swa_retry_ctrl #(.TRY_W(TRY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .alert_flag(alert_flag),
        .en_set(en_set), .en_clr(en_clr), .tries_max(tries_max),
        .tick_1s(tick_1s), .line_idle(line_idle), .tx_busy(tx_busy),
        .start(start)
    );

    swa_tx_ser #(.CELL_CYC(CELL_CYC), .LOW1_CYC(LOW1_CYC), .LOW0_CYC(LOW0_CYC)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start),
        .line_pull(line_pull), .busy(tx_busy)
    );

    assign busy = tx_busy;

    // R8: a message only begins after the line was seen quiet
    a_r8_launch_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(line_idle));
    // R10: the line is released whenever no message is in flight
    a_r10_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_pull);
endmodule

// File: tb/swire_alert_signaller_tb_top.sv
module swire_alert_signaller_tb_top;
    localparam int CELL = 20, L1 = 4, L0 = 12, BRK = 30, RCV = 8, TW = 4;
    localparam int GAP  = 8 * CELL + RCV + 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic alert_flag = 1'b0, en_set = 1'b0, en_clr = 1'b0, tick_1s = 1'b0;
    logic [TW-1:0] tries_max = '0;
    logic line_pull, busy, framer_rst, line_in;

    assign line_in = !(line_pull || host_low);

    always #5 clk = ~clk;

    swire_alert_signaller #(.CELL_CYC(CELL), .LOW1_CYC(L1), .LOW0_CYC(L0),
        .BRK_CYC(BRK), .RCV_CYC(RCV), .TRY_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull(line_pull),
        .busy(busy), .framer_rst(framer_rst), .alert_flag(alert_flag),
        .en_set(en_set), .en_clr(en_clr), .tries_max(tries_max), .tick_1s(tick_1s)
    );

    int n_run = 0, n_fail = 0;
    int msg_cnt = 0, brk_cnt = 0, nbits = 0, bad_cells = 0;
    int pull_no_busy = 0, pull_host = 0;
    int lo_len = 0, since_rise = 0;
    logic [7:0] shreg = '0;
    logic prev_pull = 1'b0;
    logic mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Line monitor: decodes pulses into bits and checks the cell shape.
    always @(negedge clk) begin
        if (mon_on) begin
            if (framer_rst) brk_cnt++;
            if (line_pull && !busy) pull_no_busy++;
            if (line_pull && host_low) pull_host++;
            if (line_pull && !prev_pull) begin
                if (nbits > 0 && since_rise != CELL) bad_cells++;   // R3 cell length
                since_rise = 1;
                lo_len = 1;
            end else begin
                since_rise++;
                if (line_pull) lo_len++;
            end
            if (!line_pull && prev_pull) begin
                if (lo_len == L1) shreg = {1'b1, shreg[7:1]};
                else if (lo_len == L0) shreg = {1'b0, shreg[7:1]};
                else bad_cells++;
                nbits++;
                if (nbits == 8) begin
                    if (shreg != 8'h80) begin
                        n_fail++;
                        $display("FAIL R3: actual byte %0d expected %0d", shreg, 8'h80);
                    end
                    msg_cnt++;
                    nbits = 0;
                end
            end
            prev_pull = line_pull;
        end
    end

    task automatic tick_wait();
        @(negedge clk) tick_1s = 1'b1;
        @(negedge clk) tick_1s = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic strobe_set();
        @(negedge clk) en_set = 1'b1;
        @(negedge clk) en_set = 1'b0;
    endtask

    task automatic strobe_clr();
        @(negedge clk) en_clr = 1'b1;
        @(negedge clk) en_clr = 1'b0;
    endtask

    task automatic hold_low(input int n);
        @(negedge clk) host_low = 1'b1;
        repeat (n) @(negedge clk);
        host_low = 1'b0;
        repeat (RCV + 4) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1: reset state
        chk(line_pull == 1'b0, "R1 line_pull", line_pull, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(framer_rst == 1'b0, "R1 framer_rst", framer_rst, 0);
        repeat (RCV + 2) @(negedge clk);

        // R2: disabled by default
        alert_flag = 1'b1;
        tries_max = 4'd3;
        repeat (3) tick_wait();
        chk(msg_cnt == 0, "R2 disabled", msg_cnt, 0);

        // R4 / R3: one well-formed message per tick
        strobe_set();
        tick_wait();
        chk(msg_cnt == 1, "R4 first tick", msg_cnt, 1);
        tick_wait();
        tick_wait();
        chk(msg_cnt == 3, "R4 per tick", msg_cnt, 3);
        // R5: limit reached
        tick_wait();
        tick_wait();
        chk(msg_cnt == 3, "R5 limit", msg_cnt, 3);

        // R7: alert drop resets tries
        @(negedge clk) alert_flag = 1'b0;
        @(negedge clk) alert_flag = 1'b1;
        tick_wait();
        chk(msg_cnt == 4, "R7 alert drop", msg_cnt, 4);
        tick_wait(); tick_wait(); tick_wait();
        chk(msg_cnt == 6, "R5 limit again", msg_cnt, 6);
        // R7: set strobe resets tries
        strobe_set();
        tick_wait();
        chk(msg_cnt == 7, "R7 re-enable", msg_cnt, 7);

        // R6: clear stops retries
        strobe_clr();
        tick_wait();
        chk(msg_cnt == 7, "R6 clear", msg_cnt, 7);
        // R6: set and clear together leave it disabled
        @(negedge clk) begin en_set = 1'b1; en_clr = 1'b1; end
        @(negedge clk) begin en_set = 1'b0; en_clr = 1'b0; end
        tick_wait();
        chk(msg_cnt == 7, "R6 clear beats set", msg_cnt, 7);
        // R6: tick in the same cycle as clear
        strobe_set();
        @(negedge clk) begin tick_1s = 1'b1; en_clr = 1'b1; end
        @(negedge clk) begin tick_1s = 1'b0; en_clr = 1'b0; end
        repeat (GAP) @(negedge clk);
        chk(msg_cnt == 7, "R6 tick with clear", msg_cnt, 7);

        // R8: tick during a host low is deferred until recovery
        strobe_set();
        base = msg_cnt;
        @(negedge clk) host_low = 1'b1;
        repeat (5) @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk) tick_1s = 1'b0;
        repeat (15) @(negedge clk);
        host_low = 1'b0;
        chk(pull_host == 0, "R8 no pull during host low", pull_host, 0);
        chk(msg_cnt == base, "R8 not yet sent", msg_cnt, base);
        repeat (GAP) @(negedge clk);
        chk(msg_cnt == base + 1, "R8 deferred message", msg_cnt, base + 1);

        // R9: break boundary
        base = brk_cnt;
        hold_low(BRK - 1);
        chk(brk_cnt == base, "R9 short low", brk_cnt, base);
        hold_low(BRK);
        chk(brk_cnt == base + 1, "R9 break", brk_cnt, base + 1);
        hold_low(BRK + 20);
        chk(brk_cnt == base + 2, "R9 long low one pulse", brk_cnt, base + 2);

        // R5 sweep over small limits, six ticks each
        for (int tm = 0; tm <= 4; tm++) begin
            tries_max = 4'(tm);
            strobe_set();
            base = msg_cnt;
            repeat (6) tick_wait();
            chk(msg_cnt - base == tm, "R5 sweep", msg_cnt - base, tm);
        end

        // R3: no trailing bits or malformed cells
        chk(nbits == 0, "R3 no extra byte", nbits, 0);
        chk(bad_cells == 0, "R3 cell shape", bad_cells, 0);
        // R10: never pulled while idle
        chk(pull_no_busy == 0, "R10 release", pull_no_busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule